// File: doc/BRIEF.md
# S/PDIF Channel Status and User Data Buffer

This block keeps the two per-block metadata streams of an S/PDIF transmitter: the 192-bit channel status block and the 192-bit user data block. Software fills each block through six 32-bit word registers. The frame serializer takes one bit of each block per frame. The block keeps its own frame position counter, which advances on a one-cycle frame strobe. It gives out the current channel status bit and user data bit, and it marks the frame that carries the block-start preamble.

Each block has two copies. Software writes land in a shadow copy. The serializer reads from an active copy. While transmission is enabled, both shadows are moved into the active copies on the strobe that ends frame 191. On that same cycle the two ready status bits are raised, so software knows it may write the next block. While transmission is off there is no block to protect, so writes go to both copies at once. A small interrupt unit has a set-style enable register, a clear-style disable register, a readable mask and a status register that clears when read. The interrupt line is high when any status bit is set and also unmasked.

Top module: `spdif_meta_buf`

## Requirements
- R1: After reset, both copies of both blocks, the mask and the status are zero, and the frame position is 0. Therefore cs_bit, ud_bit, block_start and irq are all 0.
- R2: Register addresses 0 to 5 hold the channel status words and addresses 6 to 11 hold the user data words. Word k carries block bits 32k to 32k+31. Byte 4k is in bits 7:0, and bit n of the block is word n/32, bit n mod 32. During frame n, cs_bit and ud_bit carry active bit n of their blocks.
- R3: While tx_enable is 0, a write to a data word takes effect in the active copy on the next cycle.
- R4: While tx_enable is 1, a data write changes only the shadow copy. The active copy keeps its value until the frame strobe that ends frame 191. On that strobe both active copies take the shadow values they held before that cycle.
- R5: The strobe that ends frame 191 while enabled sets status bit 0 (channel status ready) and status bit 1 (user data ready). The status is visible from the next cycle.
- R6: Writing address 12 ORs wr_data[1:0] into the mask. Writing address 13 clears the mask bits where wr_data[1:0] is 1. Reading address 14 returns the mask in bits 1:0.
- R7: irq is 1 exactly when some status bit and the matching mask bit are both 1.
- R8: Reading address 15 returns the status in bits 1:0 and clears it at the end of that cycle. If a status bit is set in the same cycle as the read, the bit stays set.
- R9: The frame position advances on frame_tick only while tx_enable is 1, and it wraps from 191 to 0. While tx_enable is 0 it is forced to 0. block_start is 1 while tx_enable is 1 and the position is 0.
- R10: Reading a data word address returns the shadow copy, which is the last value written. rd_data is combinational and is valid in the cycle rd_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmission running |
| frame_tick | input | 1 | One-cycle strobe at the end of each frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| cs_bit | output | 1 | Channel status bit for the current frame |
| ud_bit | output | 1 | User data bit for the current frame |
| block_start | output | 1 | Current frame carries the block-start preamble |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take three things for granted about the inputs. wr_en and rd_en are single-cycle strobes on one shared bus. Only one register access is made per cycle. frame_tick is a one-cycle pulse. The stimulus keeps to this: one task drives each access for exactly one cycle and then returns every strobe to idle. It also moves tx_enable only between accesses. It deliberately makes a status read coincide with the block handover, and it writes shadow words while a block is being sent, because the set-wins rule and the handover timing depend on those cases.

// File: rtl/spdif_meta_pkg.sv
package spdif_meta_pkg;
   localparam int NUM_IRQ = 2;
   localparam int IRQ_CS  = 0;
   localparam int IRQ_UD  = 1;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_CS,
      RK_UD,
      RK_IEN,
      RK_IDIS,
      RK_MASK,
      RK_STAT
   } reg_kind_e;

   // register map: cs words, ud words, then four control registers
   function automatic reg_kind_e decode_addr(input int unsigned a, input int unsigned nw);
      reg_kind_e k;
      if (a < nw)                k = RK_CS;
      else if (a < 2 * nw)       k = RK_UD;
      else if (a == 2 * nw)      k = RK_IEN;
      else if (a == 2 * nw + 1)  k = RK_IDIS;
      else if (a == 2 * nw + 2)  k = RK_MASK;
      else if (a == 2 * nw + 3)  k = RK_STAT;
      else                       k = RK_NONE;
      return k;
   endfunction
endpackage

// File: rtl/spdif_meta_bank.sv
module spdif_meta_bank #(
   parameter int WORD_W = 32,
   parameter int NWORDS = 6,
   parameter int WIDX_W = 3,
   parameter int IDX_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_stb,
   input  logic [WIDX_W-1:0]          wr_idx,
   input  logic [WORD_W-1:0]          wr_data,
   input  logic                       direct,
   input  logic                       swap,
   input  logic [WIDX_W-1:0]          rd_idx,
   input  logic [IDX_W-1:0]           bit_idx,
   output logic [WORD_W-1:0]          rd_word,
   output logic                       tx_bit,
   output logic [NWORDS*WORD_W-1:0]   active_flat
);
   localparam int BITS = NWORDS * WORD_W;

   logic [WORD_W-1:0] shadow_q [NWORDS];
   logic [WORD_W-1:0] active_q [NWORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NWORDS; k++) begin
            shadow_q[k] <= '0;
            active_q[k] <= '0;
         end
      end else begin
         for (int k = 0; k < NWORDS; k++) begin
            if (wr_stb && (wr_idx == WIDX_W'(k)))
               shadow_q[k] <= wr_data;
            if (direct && wr_stb && (wr_idx == WIDX_W'(k)))
               active_q[k] <= wr_data;
            else if (swap)
               active_q[k] <= shadow_q[k];
         end
      end
   end

   for (genvar k = 0; k < NWORDS; k++) begin : g_flat
      assign active_flat[k*WORD_W +: WORD_W] = active_q[k];
   end

   always_comb begin
      rd_word = '0;
      for (int k = 0; k < NWORDS; k++)
         if (rd_idx == WIDX_W'(k))
            rd_word = shadow_q[k];
   end

   logic [IDX_W-1:0] bit_sel;
   assign bit_sel = (int'(bit_idx) < BITS) ? bit_idx : '0;
   assign tx_bit  = active_flat[bit_sel];
endmodule

// File: rtl/spdif_meta_fcnt.sv
module spdif_meta_fcnt #(
   parameter int NFRAMES = 192,
   parameter int IDX_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick,
   output logic [IDX_W-1:0] idx,
   output logic             swap
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NFRAMES - 1);

   logic at_last;
   assign at_last = (idx == LAST);
   assign swap    = enable && tick && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (!enable)
         idx <= '0;
      else if (tick)
         idx <= at_last ? '0 : idx + 1'b1;
   end
endmodule

// File: rtl/spdif_meta_irq.sv
module spdif_meta_irq #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         mask_set,
   input  logic         mask_clr,
   input  logic [N-1:0] bits,
   input  logic         rd_clr,
   output logic [N-1:0] mask,
   output logic [N-1:0] status,
   output logic         irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask   <= '0;
         status <= '0;
      end else begin
         if (mask_set)
            mask <= mask | bits;
         else if (mask_clr)
            mask <= mask & ~bits;
         status <= (rd_clr ? '0 : status) | set_vec;
      end
   end

   assign irq = |(status & mask);
endmodule

// File: rtl/spdif_meta_buf.sv
module spdif_meta_buf
   import spdif_meta_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int BLOCK_BITS = 192,
   localparam int NWORDS    = BLOCK_BITS / WORD_W,
   localparam int ADDR_W    = $clog2(2 * NWORDS + 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_enable,
   input  logic              frame_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              cs_bit,
   output logic              ud_bit,
   output logic              block_start,
   output logic              irq
);
   localparam int WIDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
   localparam int IDX_W  = $clog2(BLOCK_BITS);
   localparam int NBANK  = 2;

   if (BLOCK_BITS % WORD_W != 0) begin : g_bad_div
      $error("BLOCK_BITS must be a multiple of WORD_W");
   end
   if (WORD_W % 8 != 0) begin : g_bad_bytes
      $error("WORD_W must be whole bytes");
   end
   if (WORD_W < NUM_IRQ) begin : g_bad_irq
      $error("WORD_W too narrow for the status bits");
   end

   reg_kind_e wr_kind, rd_kind;
   assign wr_kind = wr_en ? decode_addr(int'(wr_addr), NWORDS) : RK_NONE;
   assign rd_kind = rd_en ? decode_addr(int'(rd_addr), NWORDS) : RK_NONE;

   logic [ADDR_W-1:0] wr_off_ud, rd_off_ud;
   assign wr_off_ud = wr_addr - ADDR_W'(NWORDS);
   assign rd_off_ud = rd_addr - ADDR_W'(NWORDS);

   logic [IDX_W-1:0] frame_idx;
   logic             swap;

   spdif_meta_fcnt #(.NFRAMES(BLOCK_BITS), .IDX_W(IDX_W)) i_fcnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (tx_enable),
      .tick   (frame_tick),
      .idx    (frame_idx),
      .swap   (swap)
   );

   logic [NBANK-1:0]        bank_wr;
   logic [WIDX_W-1:0]       bank_widx [NBANK];
   logic [WIDX_W-1:0]       bank_ridx [NBANK];
   logic [WORD_W-1:0]       bank_rd   [NBANK];
   logic [NBANK-1:0]        bank_bit;
   logic [BLOCK_BITS-1:0]   bank_act  [NBANK];

   assign bank_wr[IRQ_CS]   = (wr_kind == RK_CS);
   assign bank_wr[IRQ_UD]   = (wr_kind == RK_UD);
   assign bank_widx[IRQ_CS] = wr_addr[WIDX_W-1:0];
   assign bank_widx[IRQ_UD] = wr_off_ud[WIDX_W-1:0];
   assign bank_ridx[IRQ_CS] = rd_addr[WIDX_W-1:0];
   assign bank_ridx[IRQ_UD] = rd_off_ud[WIDX_W-1:0];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      spdif_meta_bank #(
         .WORD_W (WORD_W),
         .NWORDS (NWORDS),
         .WIDX_W (WIDX_W),
         .IDX_W  (IDX_W)
      ) i_bank (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_stb      (bank_wr[b]),
         .wr_idx      (bank_widx[b]),
         .wr_data     (wr_data),
         .direct      (!tx_enable),
         .swap        (swap),
         .rd_idx      (bank_ridx[b]),
         .bit_idx     (frame_idx),
         .rd_word     (bank_rd[b]),
         .tx_bit      (bank_bit[b]),
         .active_flat (bank_act[b])
      );
   end

   logic [NUM_IRQ-1:0] irq_mask, irq_status;

   spdif_meta_irq #(.N(NUM_IRQ)) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  ({NUM_IRQ{swap}}),
      .mask_set (wr_kind == RK_IEN),
      .mask_clr (wr_kind == RK_IDIS),
      .bits     (wr_data[NUM_IRQ-1:0]),
      .rd_clr   (rd_kind == RK_STAT),
      .mask     (irq_mask),
      .status   (irq_status),
      .irq      (irq)
   );

   always_comb begin
      unique case (rd_kind)
         RK_CS:   rd_data = bank_rd[IRQ_CS];
         RK_UD:   rd_data = bank_rd[IRQ_UD];
         RK_MASK: rd_data = {{(WORD_W-NUM_IRQ){1'b0}}, irq_mask};
         RK_STAT: rd_data = {{(WORD_W-NUM_IRQ){1'b0}}, irq_status};
         default: rd_data = '0;
      endcase
   end

   assign cs_bit      = bank_bit[IRQ_CS];
   assign ud_bit      = bank_bit[IRQ_UD];
   assign block_start = tx_enable && (frame_idx == '0);
endmodule

// File: rtl/spdif_meta_chk.sv
module spdif_meta_chk #(
   parameter int ADDR_W = 4,
   parameter int NWORDS = 6,
   parameter int IDX_W  = 8,
   parameter int BITS   = 192,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_enable,
   input logic              frame_tick,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [WORD_W-1:0] wr_data,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              irq,
   input logic [IDX_W-1:0]  frame_idx,
   input logic              swap,
   input logic [1:0]        status,
   input logic [1:0]        mask,
   input logic [BITS-1:0]   cs_active
);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(2 * NWORDS);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2 * NWORDS + 3);
   localparam logic [IDX_W-1:0]  LAST   = IDX_W'(BITS - 1);

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_enable && $past(tx_enable) && !$past(swap)) |-> $stable(cs_active));

   assert_ready_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> (status == 2'b11));

   assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_IEN) |=> ((mask & $past(wr_data[1:0])) == $past(wr_data[1:0])));

   assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($countones(status & mask) > 0));

   assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == A_STAT && !swap) |=> (status == 2'b00));

   assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_enable && frame_tick && frame_idx == LAST) |=> (frame_idx == '0));

   assert_idle_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_enable |=> (frame_idx == '0));
endmodule

bind spdif_meta_buf spdif_meta_chk #(
   .ADDR_W (ADDR_W),
   .NWORDS (NWORDS),
   .IDX_W  (IDX_W),
   .BITS   (BLOCK_BITS),
   .WORD_W (WORD_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_enable  (tx_enable),
   .frame_tick (frame_tick),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .irq        (irq),
   .frame_idx  (frame_idx),
   .swap       (swap),
   .status     (irq_status),
   .mask       (irq_mask),
   .cs_active  (bank_act[0])
);

// File: tb/test_spdif_meta_buf.sv
module test_spdif_meta_buf;
   localparam int CLK_PERIOD = 10;
   localparam int NB    = 192;
   localparam int A_UD  = 6;
   localparam int A_IEN = 12;
   localparam int A_IDIS = 13;
   localparam int A_MASK = 14;
   localparam int A_STAT = 15;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        tx_enable = 0;
   logic        frame_tick = 0;
   logic        wr_en = 0;
   logic [3:0]  wr_addr = 0;
   logic [31:0] wr_data = 0;
   logic        rd_en = 0;
   logic [3:0]  rd_addr = 0;
   logic [31:0] rd_data;
   logic        cs_bit, ud_bit, block_start, irq;

   int total = 0;
   int bad   = 0;

   spdif_meta_buf i_spdif_meta_buf (
      .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .frame_tick(frame_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .cs_bit(cs_bit), .ud_bit(ud_bit), .block_start(block_start), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   logic [NB-1:0] m_cs_sh, m_cs_act, m_ud_sh, m_ud_act;
   logic [1:0]    m_mask, m_st;
   int            m_idx;

   function automatic logic [31:0] m_read(input int a);
      if (a < A_UD)        return m_cs_sh[32*a +: 32];
      else if (a < A_IEN)  return m_ud_sh[32*(a-A_UD) +: 32];
      else if (a == A_MASK) return {30'd0, m_mask};
      else if (a == A_STAT) return {30'd0, m_st};
      return 32'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cs_sh = '0; m_cs_act = '0; m_ud_sh = '0; m_ud_act = '0;
         m_mask = 0; m_st = 0; m_idx = 0;
      end else begin
         automatic bit sw = tx_enable && frame_tick && (m_idx == NB-1);
         automatic logic [NB-1:0] old_cs = m_cs_sh;
         automatic logic [NB-1:0] old_ud = m_ud_sh;
         if (sw) begin
            m_cs_act = old_cs;
            m_ud_act = old_ud;
         end
         if (wr_en) begin
            automatic int a = int'(wr_addr);
            if (a < A_UD) begin
               m_cs_sh[32*a +: 32] = wr_data;
               if (!tx_enable) m_cs_act[32*a +: 32] = wr_data;
            end else if (a < A_IEN) begin
               m_ud_sh[32*(a-A_UD) +: 32] = wr_data;
               if (!tx_enable) m_ud_act[32*(a-A_UD) +: 32] = wr_data;
            end else if (a == A_IEN) m_mask = m_mask | wr_data[1:0];
            else if (a == A_IDIS) m_mask = m_mask & ~wr_data[1:0];
         end
         if (rd_en && int'(rd_addr) == A_STAT) m_st = 2'b00;
         if (sw) m_st = 2'b11;
         if (!tx_enable) m_idx = 0;
         else if (frame_tick) m_idx = (m_idx == NB-1) ? 0 : m_idx + 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 cs_bit", {31'd0, cs_bit}, {31'd0, m_cs_act[m_idx]});
         chk("R2 ud_bit", {31'd0, ud_bit}, {31'd0, m_ud_act[m_idx]});
         chk("R9 block_start", {31'd0, block_start}, {31'd0, tx_enable && m_idx == 0});
         chk("R7 irq", {31'd0, irq}, {31'd0, |(m_st & m_mask)});
         if (rd_en) chk("R10 rd_data", rd_data, m_read(int'(rd_addr)));
      end
   end

   task automatic op(input logic tk, input logic we, input int a, input logic [31:0] d);
      frame_tick = tk; wr_en = we; wr_addr = 4'(a); wr_data = d;
      @(posedge clk); #1;
      frame_tick = 0; wr_en = 0;
   endtask

   task automatic rd(input int a, input logic tk, output logic [31:0] v);
      rd_en = 1; rd_addr = 4'(a); frame_tick = tk;
      #1 v = rd_data;
      @(posedge clk); #1;
      rd_en = 0; frame_tick = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      chk("R1 cs_bit", {31'd0, cs_bit}, 0);
      chk("R1 ud_bit", {31'd0, ud_bit}, 0);
      chk("R1 block_start", {31'd0, block_start}, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      rd(A_STAT, 0, v); chk("R1 status", v, 0);
      rd(A_MASK, 0, v); chk("R1 mask", v, 0);

      // R3 direct writes while disabled
      for (int k = 0; k < 6; k++) begin
         op(0, 1, k, 32'hC0DE_00A5 + k * 32'h0101_0100);
         op(0, 1, A_UD + k, 32'h5A5A_0000 + k * 32'h11);
      end
      chk("R3 cs_bit direct", {31'd0, cs_bit}, 1);
      chk("R3 ud_bit direct", {31'd0, ud_bit}, 0);
      rd(2, 0, v); chk("R10 cs word2", v, 32'hC0DE_00A5 + 2 * 32'h0101_0100);
      rd(A_UD + 1, 0, v); chk("R10 ud word1", v, 32'h5A5A_0011);

      // R6 mask set/clear
      op(0, 1, A_IEN, 32'h3);
      rd(A_MASK, 0, v); chk("R6 mask set", v, 3);
      op(0, 1, A_IDIS, 32'h1);
      rd(A_MASK, 0, v); chk("R6 mask clear", v, 2);
      op(0, 1, A_IEN, 32'h1);

      // R4 shadow only while enabled
      tx_enable = 1;
      op(0, 0, 0, 0);
      chk("R9 block_start at frame 0", {31'd0, block_start}, 1);
      op(0, 1, 0, 32'h0000_0000);
      chk("R4 active held", {31'd0, cs_bit}, 1);
      rd(0, 0, v); chk("R10 shadow readback", v, 0);
      for (int i = 0; i < NB - 1; i++) op(1, 0, 0, 0);
      chk("R5 no early ready", {31'd0, irq}, 0);
      op(1, 0, 0, 0);
      chk("R4 swapped content", {31'd0, cs_bit}, 0);
      chk("R9 wrapped", {31'd0, block_start}, 1);
      chk("R7 irq raised", {31'd0, irq}, 1);
      rd(A_STAT, 0, v); chk("R5 status ready", v, 3);
      rd(A_STAT, 0, v); chk("R8 read cleared", v, 0);
      chk("R7 irq dropped", {31'd0, irq}, 0);

      // sparse ticks with writes and reads, model compares each cycle
      for (int i = 0; i < 900; i++) begin
         if (i % 37 == 5) op(i % 3 == 0, 1, i % 12, $urandom);
         else if (i % 50 == 7) rd(A_STAT, i % 3 == 0, v);
         else op(i % 3 == 0, 0, 0, 0);
      end

      // R8 status read coincides with the handover
      while (m_idx != NB - 1) op(1, 0, 0, 0);
      rd(A_STAT, 0, v);
      rd(A_STAT, 1, v);
      rd(A_STAT, 0, v); chk("R8 set wins over clear", v, 3);

      // R9 ticks ignored while disabled
      repeat (5) op(1, 0, 0, 0);
      tx_enable = 0;
      op(1, 0, 0, 0);
      chk("R9 disabled no start", {31'd0, block_start}, 0);
      repeat (4) op(1, 0, 0, 0);
      op(0, 1, A_IDIS, 32'h3);
      tx_enable = 1;
      #1 chk("R9 position held at 0", {31'd0, block_start}, 1);
      for (int i = 0; i < NB; i++) op(1, 0, 0, 0);
      chk("R7 masked status no irq", {31'd0, irq}, 0);
      rd(A_STAT, 0, v); chk("R5 status with mask off", v, 3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule